// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Aggregator

The block gathers a set of level-sensitive interrupt sources, 32 or 64 of them, and presents them to a fixed number of CPUs. Each CPU has its own bank of mask words, its own round-robin pointer and its own summary interrupt line. A source is pending for a CPU when its level is high and that CPU's mask bit for it is set. The CPU never has to scan: the block proposes one pending source at a time, with no fixed priority, and the search resumes just past the source most recently acknowledged.

A small register port reads the raw source levels and reads and writes the per-CPU mask words, organised as 32-bit words. In the 64-source form the word at index 0 carries the upper half of the sources. A contiguous range of source numbers can be marked as cascaded external lines. When the proposed source lies in that range, it is reported relative to the start of the range, together with a flag.

Top module: `irq_rr_aggr`

## Requirements
- R1: A source is offered to a CPU (nxt_valid high) only when its level input is 1 and that CPU's mask bit for it is 1. A source whose level is high but whose mask bit is 0 is never offered.
- R2: Synchronous active-high reset clears every mask word of every CPU to zero, sets each round-robin pointer to source 0 and drives irq_out low. Right after reset no source is offered, even with all levels high.
- R3: Register word w (reg_word) maps to sources ((w XOR (WORDS-1))*32) to that value plus 31, with source s in bit s mod 32. With 64 sources, word 0 holds sources 32..63 and word 1 holds sources 0..31. reg_kind=0 reads the raw levels. reg_kind=1 reads the mask word of CPU reg_cpu, and writes it when reg_we is high. Reads are combinational, and a write takes effect at the next rising edge.
- R4: The offered source is the first pending source met when counting upward from the CPU's pointer (the pointer itself included), wrapping from NUM_SRC-1 to 0.
- R5: When nxt_ack of a CPU is high at a rising edge while that CPU offers source s, its pointer becomes (s+1) mod NUM_SRC.
- R6: When nxt_ack is high at an edge while nothing is offered, the pointer is left unchanged.
- R7: When the offered source s lies in [EXT_START, EXT_END] (default 40..43), nxt_ext is 1 and the CPU's nxt_idx field (bits c*IW up to c*IW+IW-1, with IW=log2(NUM_SRC)) carries s-EXT_START. Otherwise nxt_ext is 0 and the field carries s.
- R8: irq_out of a CPU is the OR of all its pending bits as they were before the latest rising edge, so it follows a change in levels or mask one cycle later.
- R9: The CPUs are independent. A mask write to one CPU, or an acknowledge from it, changes neither what another CPU offers nor its pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NUM_SRC | Level of each interrupt source |
| reg_we | input | 1 | Mask word write strobe |
| reg_cpu | input | CPU_W | CPU whose mask bank is addressed |
| reg_kind | input | 1 | 0 reads source levels, 1 accesses the mask |
| reg_word | input | WIDX | Register word index |
| reg_wdata | input | 32 | Mask write data |
| reg_rdata | output | 32 | Read data for the addressed word |
| nxt_ack | input | NUM_CPU | Per-CPU acknowledge of the offered source |
| nxt_valid | output | NUM_CPU | Per-CPU: a source is offered |
| nxt_idx | output | NUM_CPU*IW | Per-CPU offered index, remapped for external sources |
| nxt_ext | output | NUM_CPU | Per-CPU: the offered source is a cascaded external line |
| irq_out | output | NUM_CPU | Per-CPU registered summary interrupt |

## Verification
An acknowledge and a mask write can reach the same CPU at the same rising edge. The pointer then moves past the source offered before the edge, while the new mask decides what is offered after it. The bench provokes this by acknowledging CPU 1 in the cycle that clears the mask bit of the source that would otherwise follow. It requires that the wrapped-around source is offered next and that the cleared source is skipped.

// File: rtl/irq_rr_pkg.sv
package irq_rr_pkg;

    localparam int WORD_W = 32;

    typedef enum logic {
        REG_LEVEL = 1'b0,
        REG_MASK  = 1'b1
    } reg_kind_e;

    // first source held by register word w, given the number of words
    function automatic int word_first_src(input int w, input int words);
        return (w ^ (words - 1)) * WORD_W;
    endfunction

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_rr_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int WIDX    = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [WIDX-1:0]      word,
    input  logic [WORD_W-1:0]    wdata,
    output logic [NUM_SRC-1:0]   mask
);
    localparam int WORDS = NUM_SRC / WORD_W;

    logic [WORDS-1:0][WORD_W-1:0] words_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (we && word == w[WIDX-1:0]) begin
                    words_q[w] <= wdata;
                end
            end
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_map
        localparam int BASE = word_first_src(w, WORDS);
        assign mask[BASE +: WORD_W] = words_q[w];
    end

    assert_mask_clear_R2 : assert property (@(posedge clk)
        $past(rst) |-> (mask == '0));

endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
    parameter int NUM_SRC = 64,
    parameter int IW      = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend,
    input  logic               ack,
    output logic               hit,
    output logic [IW-1:0]      sel,
    output logic               irq
);
    typedef struct packed {
        logic          hit;
        logic [IW-1:0] src;
    } pick_t;

    logic [IW-1:0] ptr_q;
    pick_t         pick;

    always_comb begin
        logic [IW-1:0] cand;
        pick = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            cand = ptr_q + k[IW-1:0];
            if (!pick.hit && pend[cand]) begin
                pick.hit = 1'b1;
                pick.src = cand;
            end
        end
    end

    assign hit = pick.hit;
    assign sel = pick.src;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= |pend;
            if (ack && pick.hit) begin
                ptr_q <= pick.src + 1'b1;
            end
        end
    end

    assert_pick_pending_R1 : assert property (@(posedge clk) disable iff (rst)
        hit |-> pend[sel]);

    assert_scan_first_R4 : assert property (@(posedge clk) disable iff (rst)
        (hit && sel != ptr_q) |-> !pend[ptr_q]);

    assert_ptr_advance_R5 : assert property (@(posedge clk) disable iff (rst)
        (ack && hit) |=> (ptr_q == $past(sel) + 1'b1));

    assert_ptr_hold_R6 : assert property (@(posedge clk) disable iff (rst)
        (ack && !hit) |=> $stable(ptr_q));

    assert_irq_rise_R8 : assert property (@(posedge clk) disable iff (rst)
        (|pend) |=> irq);

    assert_irq_fall_R8 : assert property (@(posedge clk) disable iff (rst)
        !(|pend) |=> !irq);

endmodule

// File: rtl/irq_ext_remap.sv
module irq_ext_remap #(
    parameter int NUM_SRC   = 64,
    parameter int IW        = 6,
    parameter int EXT_START = 40,
    parameter int EXT_END   = 43
) (
    input  logic [IW-1:0] src,
    output logic [IW-1:0] idx,
    output logic          ext
);
    localparam logic [IW-1:0] START_V = IW'(EXT_START);

    always_comb begin
        ext = (int'(src) >= EXT_START) && (int'(src) <= EXT_END);
        idx = ext ? (src - START_V) : src;
    end

endmodule

// File: rtl/irq_rr_aggr.sv
module irq_rr_aggr
    import irq_rr_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_CPU   = 2,
    parameter int EXT_START = 40,
    parameter int EXT_END   = 43,
    localparam int WORDS    = NUM_SRC / WORD_W,
    localparam int WIDX     = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IW       = $clog2(NUM_SRC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    src_lvl,
    input  logic                  reg_we,
    input  logic [CPU_W-1:0]      reg_cpu,
    input  logic                  reg_kind,
    input  logic [WIDX-1:0]       reg_word,
    input  logic [WORD_W-1:0]     reg_wdata,
    output logic [WORD_W-1:0]     reg_rdata,
    input  logic [NUM_CPU-1:0]    nxt_ack,
    output logic [NUM_CPU-1:0]    nxt_valid,
    output logic [NUM_CPU*IW-1:0] nxt_idx,
    output logic [NUM_CPU-1:0]    nxt_ext,
    output logic [NUM_CPU-1:0]    irq_out
);
    logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_all;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic               we_c;
        logic [NUM_SRC-1:0] pend_c;
        logic [IW-1:0]      sel_c;

        assign we_c   = reg_we && (reg_kind == REG_MASK) && (int'(reg_cpu) == c);
        assign pend_c = src_lvl & mask_all[c];

        irq_mask_bank #(.NUM_SRC(NUM_SRC), .WIDX(WIDX)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (we_c),
            .word  (reg_word),
            .wdata (reg_wdata),
            .mask  (mask_all[c])
        );

        irq_rr_pick #(.NUM_SRC(NUM_SRC), .IW(IW)) u_pick (
            .clk  (clk),
            .rst  (rst),
            .pend (pend_c),
            .ack  (nxt_ack[c]),
            .hit  (nxt_valid[c]),
            .sel  (sel_c),
            .irq  (irq_out[c])
        );

        irq_ext_remap #(.NUM_SRC(NUM_SRC), .IW(IW),
                        .EXT_START(EXT_START), .EXT_END(EXT_END)) u_remap (
            .src (sel_c),
            .idx (nxt_idx[c*IW +: IW]),
            .ext (nxt_ext[c])
        );

        assert_ext_span_R7 : assert property (@(posedge clk) disable iff (rst)
            (nxt_valid[c] && nxt_ext[c]) |->
                (int'(nxt_idx[c*IW +: IW]) <= EXT_END - EXT_START));

        assert_offer_masked_R1 : assert property (@(posedge clk) disable iff (rst)
            nxt_valid[c] |-> (src_lvl[sel_c] && mask_all[c][sel_c]));
    end

    always_comb begin
        int base;
        reg_rdata = '0;
        base = word_first_src(int'(reg_word), WORDS);
        if (int'(reg_word) < WORDS) begin
            if (reg_kind == REG_LEVEL) begin
                reg_rdata = src_lvl[base +: WORD_W];
            end else begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    if (int'(reg_cpu) == c) begin
                        reg_rdata = mask_all[c][base +: WORD_W];
                    end
                end
            end
        end
    end

endmodule

// File: tb/irq_rr_aggr_tb_top.sv
module irq_rr_aggr_tb_top;
    localparam int NROW = 13;
    localparam int IW   = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_lvl = '0;
    logic        reg_we = 1'b0;
    logic        reg_cpu = 1'b0;
    logic        reg_kind = 1'b0;
    logic        reg_word = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  nxt_ack = '0;
    logic [1:0]  nxt_valid;
    logic [11:0] nxt_idx;
    logic [1:0]  nxt_ext;
    logic [1:0]  irq_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    irq_rr_aggr dut_i (
        .clk(clk), .rst(rst), .src_lvl(src_lvl),
        .reg_we(reg_we), .reg_cpu(reg_cpu), .reg_kind(reg_kind),
        .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nxt_ack(nxt_ack), .nxt_valid(nxt_valid), .nxt_idx(nxt_idx),
        .nxt_ext(nxt_ext), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    localparam logic [63:0] T_SRC [NROW] = '{
        64'h0000_0000_0000_0408, 64'h0000_0000_0000_0408, 64'h0000_0000_0000_0408,
        64'h0000_0000_0000_0408, 64'h8000_0000_0000_0020, 64'h8000_0000_0000_0020,
        64'h0000_0200_0000_0000, 64'h0004_0900_0000_0000, 64'h0004_0900_0000_0000,
        64'h0004_0900_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0300_0000_0000,
        64'h0000_0400_0010_0000};
    localparam logic [63:0] T_MASK [NROW] = '{
        '1, '1, '1, 64'h400, '1, '1, '1, '1, '1, '1, '1, '1, 64'h0010_0000};
    localparam logic T_VALID [NROW] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1};
    localparam int   T_SEL   [NROW] = '{3, 10, 3, 10, 63, 5, 41, 43, 50, 40, 0, 41, 20};
    localparam string T_TAG  [NROW] = '{"R4", "R5", "R4", "R1", "R4", "R5",
        "R7", "R7", "R7", "R7", "R6", "R6", "R1"};

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_mask(input logic cpu, input logic word, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_cpu = cpu; reg_kind = 1'b1; reg_word = word; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic wr_mask64(input logic cpu, input logic [63:0] m);
        wr_mask(cpu, 1'b0, m[63:32]);
        wr_mask(cpu, 1'b1, m[31:0]);
    endtask

    task automatic ack(input int cpu);
        @(negedge clk);
        nxt_ack[cpu] = 1'b1;
        @(negedge clk);
        nxt_ack = '0;
        #1;
    endtask

    task automatic set_src(input logic [63:0] s);
        @(negedge clk);
        src_lvl = s;
        #1;
    endtask

    task automatic rd(input logic cpu, input logic kind, input logic word);
        @(negedge clk);
        reg_cpu = cpu; reg_kind = kind; reg_word = word;
        #1;
    endtask

    function automatic int exp_idx(input int s);
        return (s >= 40 && s <= 43) ? s - 40 : s;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        src_lvl = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R2: reset state with every level high
        check("R2 valid after reset", 64'(nxt_valid), 64'h0);
        check("R2 irq after reset", 64'(irq_out), 64'h0);
        rd(1'b0, 1'b1, 1'b0);
        check("R2 cpu0 mask word0", 64'(reg_rdata), 64'h0);
        rd(1'b1, 1'b1, 1'b1);
        check("R2 cpu1 mask word1", 64'(reg_rdata), 64'h0);

        // table walk on CPU 0, pointer starts at 0
        for (int r = 0; r < NROW; r++) begin
            wr_mask64(1'b0, T_MASK[r]);
            set_src(T_SRC[r]);
            check({T_TAG[r], " valid"}, 64'(nxt_valid[0]), 64'(T_VALID[r]));
            if (T_VALID[r]) begin
                check({T_TAG[r], " idx"}, 64'(nxt_idx[0 +: IW]), 64'(exp_idx(T_SEL[r])));
                check({T_TAG[r], " ext"}, 64'(nxt_ext[0]),
                      64'(T_SEL[r] >= 40 && T_SEL[r] <= 43));
            end
            if (r == 0) check("R9 cpu1 silent", 64'(nxt_valid[1]), 64'h0);
            ack(0);
        end

        // R3: word order and bit position
        wr_mask(1'b0, 1'b0, 32'h0000_0001);
        wr_mask(1'b0, 1'b1, 32'h0000_0000);
        set_src(64'h0000_0001_0000_0000);
        check("R3 source 32 offered", 64'(nxt_valid[0]), 64'h1);
        check("R3 source 32 idx", 64'(nxt_idx[0 +: IW]), 64'd32);
        set_src(64'h0000_0000_0000_0001);
        check("R3 source 0 masked", 64'(nxt_valid[0]), 64'h0);
        rd(1'b0, 1'b1, 1'b0);
        check("R3 mask word0 read", 64'(reg_rdata), 64'h1);
        rd(1'b0, 1'b1, 1'b1);
        check("R3 mask word1 read", 64'(reg_rdata), 64'h0);
        set_src(64'h0000_0005_0000_00A0);
        rd(1'b0, 1'b0, 1'b0);
        check("R3 level word0 read", 64'(reg_rdata), 64'h5);
        rd(1'b0, 1'b0, 1'b1);
        check("R3 level word1 read", 64'(reg_rdata), 64'hA0);

        // R8: summary one cycle behind the mask
        wr_mask64(1'b0, 64'h0);
        set_src(64'h80);
        @(negedge clk); #1;
        check("R8 irq low", 64'(irq_out[0]), 64'h0);
        wr_mask(1'b0, 1'b1, 32'h80);
        check("R8 irq not yet", 64'(irq_out[0]), 64'h0);
        @(negedge clk); #1;
        check("R8 irq high", 64'(irq_out[0]), 64'h1);
        wr_mask(1'b0, 1'b1, 32'h0);
        check("R8 irq still high", 64'(irq_out[0]), 64'h1);
        @(negedge clk); #1;
        check("R8 irq dropped", 64'(irq_out[0]), 64'h0);

        // R9: CPUs independent (cpu0 pointer 21, cpu1 pointer 0)
        wr_mask(1'b1, 1'b1, 32'hFFFF_FFFF);
        wr_mask(1'b0, 1'b1, 32'hFFFF_FFFF);
        set_src(64'h0000_0000_0000_0204);
        check("R9 cpu1 idx", 64'(nxt_idx[IW +: IW]), 64'd2);
        check("R4 cpu0 wrap idx", 64'(nxt_idx[0 +: IW]), 64'd2);
        ack(0);
        check("R5 cpu0 next", 64'(nxt_idx[0 +: IW]), 64'd9);
        ack(0);
        check("R4 cpu0 wrap again", 64'(nxt_idx[0 +: IW]), 64'd2);
        check("R9 cpu1 unmoved", 64'(nxt_idx[IW +: IW]), 64'd2);

        // acknowledge and mask write on CPU 1 at the same edge
        @(negedge clk);
        nxt_ack[1] = 1'b1;
        reg_we = 1'b1; reg_cpu = 1'b1; reg_kind = 1'b1; reg_word = 1'b1;
        reg_wdata = ~32'h0000_0200;
        @(negedge clk);
        nxt_ack = '0; reg_we = 1'b0;
        #1;
        check("R5 cpu1 after ack+write", 64'(nxt_idx[IW +: IW]), 64'd2);
        check("R1 cpu1 still valid", 64'(nxt_valid[1]), 64'h1);

        // R2: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R2 valid after re-reset", 64'(nxt_valid), 64'h0);
        check("R2 irq after re-reset", 64'(irq_out), 64'h0);
        rd(1'b1, 1'b1, 1'b1);
        check("R2 cpu1 mask cleared", 64'(reg_rdata), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule